// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

A register-mapped countdown timer for a core's local interrupt controller. Software loads a start value, picks a clock prescale and sets a mode word holding an interrupt vector, a mask bit and a mode. The counter then runs down at the prescaled rate. When it reaches zero the block emits a single-cycle interrupt pulse carrying the vector. Depending on the mode, the counter then reloads or stops. A third mode ignores the countdown and fires once when a free-running 64-bit timestamp counter reaches a programmed deadline.

The timer is built to be reprogrammed while it runs. Changing the prescale acts on the remaining count at once. Switching between one-shot and periodic leaves the countdown untouched, because the mode word is only read at the zero crossing. Only a move into or out of deadline mode resets the timer state. Periodic mode enforces a minimum reload value, so a tiny period cannot flood the core with interrupts.

All access goes through one write/read port: a write strobe, a 3-bit address, write data, and combinational read data.

Top module: `local_irq_timer`

## Requirements
- R1: The register map is: address 0 start value, 1 current count (read-only), 2 prescale, 3 mode word, 4 deadline low half, 5 deadline high half, 6 timestamp low half, 7 timestamp high half. Writing a nonzero value to address 0 outside deadline mode loads the current count with it and arms the countdown, with no other write needed. With prescale 1, the interrupt appears N clock edges after the write edge.
- R2: The count decrements once per prescaler tick. The tick rate is the clock divided by a factor chosen by prescale bits {3,1,0}: pattern 111 gives 1, and any other pattern v gives 2^(v+1).
- R3: A write to the mode word does not alter the running count.
- R4: The mode word holds the vector in bits 7:0, a mask in bit 16 and the mode in bits 18:17 (00 one-shot, 01 periodic, 10 deadline). The mask is set after reset. At the zero crossing, an unmasked timer raises irq_pulse for one cycle with irq_vector equal to the vector. A masked timer raises no pulse but still reloads or stops as its mode dictates.
- R5: In one-shot mode the count stays at zero after the crossing, the timer disarms, and exactly one pulse is produced.
- R6: In periodic mode the count reloads from the start value, giving pulses spaced start-value times prescale factor cycles apart.
- R7: Writing zero to the start value disarms the timer, and no pulse follows.
- R8: A switch between one-shot and periodic neither restarts nor disarms the countdown. The remaining count carries on, and the new mode applies at the next crossing.
- R9: A mode write that enters or leaves deadline mode disarms the countdown and clears the start value and the deadline to zero.
- R10: A prescale write changes the rate of the remaining count immediately.
- R11: In periodic mode, a nonzero start value below MIN_PERIOD is raised to MIN_PERIOD. This applies both on a write in periodic mode and on a switch from one-shot to periodic.
- R12: In deadline mode, a nonzero deadline fires once, when the timestamp is greater than or equal to it, and then reads back as zero. Writing zero to the deadline disarms it.
- R13: The current count reads zero whenever the countdown is disarmed or the mode is deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector accompanying irq_pulse |

## Verification
The bench goes after reconfiguration of a running timer. In one test the prescale changes mid-count: a design that applies it only at reload fires about 60 cycles early. In another the mode flips between one-shot and periodic mid-count: a design that restarts the count delays the first pulse, and one that disarms never fires. It also drives a one-shot-to-periodic switch with a start value below the floor, which an unclamped design answers with a short period, and it checks that entering deadline mode kills a running countdown and clears the start value. Masked crossings must keep reloading silently, and a zeroed deadline must stay silent.

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
  parameter int DATA_W     = 32,
  parameter int VEC_W      = 8,
  parameter int MIN_PERIOD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int TS_W = 2 * DATA_W;
  localparam logic [1:0] M_PER = 2'b01, M_DL = 2'b10;
  localparam logic [2:0] A_INIT = 3'd0, A_CUR = 3'd1, A_DIV = 3'd2, A_MODE = 3'd3,
                         A_DLO = 3'd4, A_DHI = 3'd5, A_TLO = 3'd6, A_THI = 3'd7;

  logic [DATA_W-1:0] init_q, cur_q;
  logic              armed_q, mask_q;
  logic [3:0]        div_q;
  logic [VEC_W-1:0]  vec_q;
  logic [1:0]        mode_q;
  logic [TS_W-1:0]   dl_q, tsc_q;
  logic [6:0]        pre_q;

  function automatic logic [DATA_W-1:0] floor_fn(input logic [DATA_W-1:0] v);
    return (v != '0 && v < DATA_W'(MIN_PERIOD)) ? DATA_W'(MIN_PERIOD) : v;
  endfunction

  wire       is_dl = (mode_q == M_DL);
  wire       is_per = (mode_q == M_PER);
  wire [2:0] dsel = {div_q[3], div_q[1:0]};
  wire [2:0] shift = (dsel == 3'b111) ? 3'd0 : dsel + 3'd1;
  wire [7:0] pmask = (8'd1 << shift) - 8'd1;
  wire       tick = ((pre_q & pmask[6:0]) == pmask[6:0]);

  wire       zero_hit = armed_q && !is_dl && tick && (cur_q == DATA_W'(1));
  wire       dl_hit = is_dl && (dl_q != '0) && (tsc_q >= dl_q);

  wire       wr_init = reg_wr && reg_addr == A_INIT;
  wire       wr_mode = reg_wr && reg_addr == A_MODE;
  wire [1:0] new_mode = reg_wdata[18:17];
  wire       crossing = wr_mode && ((new_mode == M_DL) != is_dl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0; cur_q <= '0; armed_q <= 1'b0;
      div_q <= '0; vec_q <= '0; mask_q <= 1'b1; mode_q <= '0;
      dl_q <= '0; tsc_q <= '0; pre_q <= '0;
      irq_pulse <= 1'b0; irq_vector <= '0;
    end else begin
      pre_q <= pre_q + 7'd1;
      tsc_q <= tsc_q + TS_W'(1);
      irq_pulse <= (zero_hit || dl_hit) && !mask_q;
      irq_vector <= vec_q;

      if (zero_hit) begin
        if (is_per) cur_q <= init_q;
        else begin
          cur_q <= '0;
          armed_q <= 1'b0;
        end
      end else if (armed_q && !is_dl && tick) begin
        cur_q <= cur_q - DATA_W'(1);
      end
      if (dl_hit) dl_q <= '0;

      if (wr_init && !is_dl) begin
        init_q <= is_per ? floor_fn(reg_wdata) : reg_wdata;
        cur_q <= is_per ? floor_fn(reg_wdata) : reg_wdata;
        armed_q <= (reg_wdata != '0);
      end
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[3:0];
      if (wr_mode) begin
        vec_q <= reg_wdata[VEC_W-1:0];
        mask_q <= reg_wdata[16];
        mode_q <= new_mode;
        if (crossing) begin
          armed_q <= 1'b0; cur_q <= '0; init_q <= '0; dl_q <= '0;
        end else if (new_mode == M_PER && !is_per) begin
          init_q <= floor_fn(init_q);
        end
      end
      if (reg_wr && reg_addr == A_DLO && is_dl) dl_q[DATA_W-1:0] <= reg_wdata;
      if (reg_wr && reg_addr == A_DHI && is_dl) dl_q[TS_W-1:DATA_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_INIT: reg_rdata = init_q;
      A_CUR:  reg_rdata = (armed_q && !is_dl) ? cur_q : '0;
      A_DIV:  reg_rdata = DATA_W'(div_q);
      A_MODE: begin
        reg_rdata[VEC_W-1:0] = vec_q;
        reg_rdata[16] = mask_q;
        reg_rdata[18:17] = mode_q;
      end
      A_DLO:  reg_rdata = dl_q[DATA_W-1:0];
      A_DHI:  reg_rdata = dl_q[TS_W-1:DATA_W];
      A_TLO:  reg_rdata = tsc_q[DATA_W-1:0];
      A_THI:  reg_rdata = tsc_q[TS_W-1:DATA_W];
      default: reg_rdata = '0;
    endcase
  end

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && !is_dl && !is_per && reg_wdata != '0) |=> (armed_q && cur_q == $past(reg_wdata))); // R1
  AST_CUR_LE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !is_dl) |-> (cur_q <= init_q)); // R2
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && !is_per && !reg_wr) |=> (!armed_q && cur_q == '0)); // R5
  AST_ZERO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && !is_dl && reg_wdata == '0) |=> !armed_q); // R7
  AST_DL_CROSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    crossing |=> (!armed_q && init_q == '0 && dl_q == '0)); // R9
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_per && armed_q) |-> (init_q >= DATA_W'(MIN_PERIOD))); // R11
  AST_DL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_hit && !reg_wr) |=> (dl_q == '0)); // R12
  AST_CUR_READ_DL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dl && reg_addr == A_CUR) |-> (reg_rdata == '0)); // R13
endmodule

// File: tb/test_local_irq_timer.sv
module test_local_irq_timer;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq_pulse;
  logic [7:0] irq_vector;
  int cyc = 0, total = 0, bad = 0, wcyc = 0;
  bit done = 0;

  local_irq_timer #(.DATA_W(DW), .VEC_W(8), .MIN_PERIOD(16)) i_local_irq_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .irq_vector(irq_vector));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int NROW = 6;
  localparam logic [3:0] T_DIV [NROW] = '{4'b1011, 4'b0000, 4'b0001, 4'b1010, 4'b0011, 4'b1011};
  localparam int T_N   [NROW] = '{20, 20, 17, 16, 30, 5};
  localparam int T_GAP [NROW] = '{20, 40, 68, 2048, 480, 16};

  function automatic logic [DW-1:0] mw(input int vec, input bit msk, input logic [1:0] md);
    return (DW'(md) << 17) | (DW'(msk) << 16) | DW'(vec);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0; wcyc = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_pulse(input int maxc, output int at, output int vec);
    at = -1; vec = -1;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (irq_pulse) begin at = cyc; vec = int'(irq_vector); return; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r, a, b;
    int p1, p2, v, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd1, r); chk("R13 reset cur", r, 0);
    rd(3'd0, r); chk("R1 reset start", r, 0);
    chk("R4 reset pulse", irq_pulse, 0);
    rd(3'd3, r); chk("R4 reset mask", r[16], 1);

    // vector table: periodic gap = N * factor (clamped rows use the floor)
    wr(3'd3, mw(8'h40, 0, 2'b01));
    for (int i = 0; i < NROW; i++) begin
      wr(3'd2, DW'(T_DIV[i]));
      wr(3'd0, DW'(T_N[i])); st = wcyc;
      wait_pulse(5000, p1, v);
      if (i == 0) chk("R1 first pulse delay", p1 - st, T_N[i]);
      chk("R4 vector", v, 8'h40);
      wait_pulse(5000, p2, v);
      chk($sformatf("R6 R2 gap row %0d", i), p2 - p1, T_GAP[i]);
      if (i == NROW - 1) begin rd(3'd0, r); chk("R11 write clamp", r, 16); end
      wr(3'd0, 0);
    end
    wait_pulse(100, p1, v); chk("R7 no pulse after zero", p1, -1);
    rd(3'd1, r); chk("R7 cur zero", r, 0);

    // one-shot
    wr(3'd2, 4'b1011);
    wr(3'd3, mw(8'h21, 0, 2'b00));
    wr(3'd0, 30); st = wcyc;
    wait_pulse(100, p1, v);
    chk("R5 one-shot delay", p1 - st, 30); chk("R4 one-shot vector", v, 8'h21);
    wait_pulse(200, p2, v); chk("R5 single pulse", p2, -1);
    rd(3'd1, r); chk("R5 R13 cur after", r, 0);

    // mode write leaves count alone
    wr(3'd0, 1000);
    rd(3'd1, a); wr(3'd3, mw(8'h22, 0, 2'b00)); rd(3'd1, b);
    chk("R3 count untouched", a - b, 3);
    wr(3'd0, 0);

    // masked periodic keeps reloading
    wr(3'd3, mw(8'h23, 1, 2'b01));
    wr(3'd0, 20);
    wait_pulse(100, p1, v); chk("R4 masked silent", p1, -1);
    rd(3'd1, r); chk("R4 masked reload armed", (r != 0 && r <= 20), 1);
    wr(3'd0, 0);

    // one-shot -> periodic -> one-shot mid-count
    wr(3'd3, mw(8'h24, 0, 2'b00));
    wr(3'd0, 200); st = wcyc;
    repeat (50) @(negedge clk);
    wr(3'd3, mw(8'h24, 0, 2'b01));
    wait_pulse(300, p1, v); chk("R8 continues into periodic", p1 - st, 200);
    wait_pulse(300, p2, v); chk("R8 periodic after switch", p2 - p1, 200);
    wr(3'd3, mw(8'h24, 0, 2'b00));
    wait_pulse(300, p1, v); chk("R8 back to one-shot", p1 - p2, 200);
    wait_pulse(400, p2, v); chk("R8 one-shot ends", p2, -1);

    // switch to periodic with small start value
    wr(3'd0, 10); st = wcyc;
    wr(3'd3, mw(8'h25, 0, 2'b01));
    rd(3'd0, r); chk("R11 switch clamp", r, 16);
    wait_pulse(100, p1, v); chk("R8 remaining after clamp", p1 - st, 10);
    wait_pulse(100, p2, v); chk("R11 clamped period", p2 - p1, 16);
    wr(3'd0, 0);

    // divide change mid-count
    wr(3'd3, mw(8'h26, 0, 2'b00));
    wr(3'd0, 100); st = wcyc;
    repeat (40) @(negedge clk);
    wr(3'd2, 4'b0000);
    wait_pulse(400, p1, v);
    chk("R10 immediate divide", (p1 - st >= 155 && p1 - st <= 165), 1);

    // deadline mode
    wr(3'd2, 4'b1011);
    wr(3'd0, 500);
    wr(3'd3, mw(8'h77, 0, 2'b10));
    rd(3'd0, r); chk("R9 start cleared", r, 0);
    rd(3'd1, r); chk("R13 cur in deadline", r, 0);
    wait_pulse(600, p1, v); chk("R9 countdown dead", p1, -1);
    rd(3'd6, r);
    wr(3'd5, 0);
    wr(3'd4, r + 60);
    wait_pulse(200, p1, v); chk("R12 deadline fires", (p1 != -1), 1);
    chk("R12 deadline vector", v, 8'h77);
    rd(3'd4, r); chk("R12 deadline cleared", r, 0);
    wait_pulse(200, p2, v); chk("R12 fires once", p2, -1);
    rd(3'd6, r);
    wr(3'd4, r + 100);
    wr(3'd4, 0);
    wait_pulse(300, p1, v); chk("R12 zero disarms", p1, -1);
    rd(3'd6, r);
    wr(3'd4, r + 5000);
    wr(3'd3, mw(8'h78, 0, 2'b00));
    rd(3'd4, r); chk("R9 deadline cleared on exit", r, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule